// File: doc/BRIEF.md
# Peripheral Port Handshake Controller

This block runs the two control lines that go with one parallel peripheral port. The first control line is only an input. Its active edge raises an interrupt flag and, when latching is on, captures the port's input pins into a holding register. The second control line can work in one of two ways. It can be an edge-sensitive interrupt input, whose flag is either cleared by port data traffic or left for software to clear. It can also be an output: a transfer handshake, a one-cycle strobe, or a fixed level.

A 4-bit mode field selects the behaviour. Bit 0 picks the active edge of the first control line: 1 selects the rising edge and 0 the falling edge. Bits 3:1 pick the mode of the second line. The bus decoder reports each port data access together with a flag. The flag tells whether the access used the address that carries handshake side effects. Both control inputs are asynchronous. Each one passes through a parameterized synchronizer chain, and a registered compare then finds its edges.

Top module: `port_handshake_ctrl`

## Requirements
- R1: While reset is held, both flags read 0, `c2Out` reads 1, `c2OutEn` reads 0 and the capture register holds 0.
- R2: With the pin held stable, `c1Flag` reads 1 after the (SYNC_STAGES+1)-th rising clock edge after the `c1In` transition selected by `ctrlField[0]` (1 = rising, 0 = falling). A handshaking access (`portAccess` and `handshakeAddr` both 1) clears the flag one edge later. If a set and a clear happen in the same cycle, the set wins.
- R3: In C2 modes 3'b000 (falling) and 3'b010 (rising), `c2Flag` sets on that `c2In` edge, with the same latency as R2, and a handshaking access clears it.
- R4: In C2 modes 3'b001 (falling) and 3'b011 (rising), `c2Flag` sets on the edge and a handshaking access leaves it set.
- R5: In C2 mode 3'b100, a handshaking access drives `c2Out` low from the next edge. The next active C1 edge returns it high. If an access and a C1 edge fall in the same cycle, the output goes low.
- R6: In C2 mode 3'b101, `c2Out` is low for exactly the one cycle after each handshaking access.
- R7: C2 mode 3'b110 drives `c2Out` low and mode 3'b111 drives it high. `c2OutEn` is 1 exactly in modes 3'b1xx, and in those modes `c2Flag` is held at 0.
- R8: An access with `handshakeAddr` = 0 changes neither flag nor `c2Out`.
- R9: With `latchEn` = 1, `dataOut` shows the `portIn` value sampled at the edge where the active C1 transition is detected, and it holds that value until the next active C1 transition.
- R10: With `latchEn` = 0, `dataOut` follows `portIn` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlField | input | 4 | [0] C1 edge select, [3:1] C2 mode |
| latchEn | input | 1 | Enables capture of port input on active C1 edge |
| portAccess | input | 1 | A port data register access happens this cycle |
| handshakeAddr | input | 1 | The access uses the address with handshake side effects |
| c1In | input | 1 | Control line 1 pin (input only) |
| c2In | input | 1 | Control line 2 pin, input value |
| portIn | input | WIDTH | Port input pins |
| c1Flag | output | 1 | C1 interrupt flag |
| c2Flag | output | 1 | C2 interrupt flag |
| c2Out | output | 1 | Control line 2 output value |
| c2OutEn | output | 1 | Control line 2 output enable |
| dataOut | output | WIDTH | Port data as seen by a read |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 3. This depth is one deeper than the default, so the flag and capture latency must follow the parameter rather than a fixed two-stage delay. A tuned delay line in the reference model catches an off-by-one in the chain. Directed sequences step through all eight C2 modes and both C1 edge polarities. A long random phase then mixes mode changes with accesses and pin toggles. That mix reaches same-cycle collisions, such as an access together with an edge.

// File: rtl/phs_pkg.sv
package phs_pkg;

  typedef enum logic [2:0] {
    C2_IN_FALL     = 3'b000,
    C2_IN_FALL_IND = 3'b001,
    C2_IN_RISE     = 3'b010,
    C2_IN_RISE_IND = 3'b011,
    C2_HANDSHAKE   = 3'b100,
    C2_PULSE       = 3'b101,
    C2_LOW         = 3'b110,
    C2_HIGH        = 3'b111
  } c2mode_e;

  // Edge events found by the datapath
  typedef struct packed {
    logic c1Rise;
    logic c1Fall;
    logic c2Rise;
    logic c2Fall;
  } edgeEvt_t;

  // Strobes from control back to the datapath
  typedef struct packed {
    logic capture;
  } ctlStrobe_t;

endpackage

// File: rtl/phs_datapath.sv
module phs_datapath
  import phs_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             c1In,
  input  logic             c2In,
  input  logic [WIDTH-1:0] portIn,
  input  logic             latchEn,
  input  ctlStrobe_t       ctl,
  output edgeEvt_t         evt,
  output logic [WIDTH-1:0] dataOut
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawLine;
  logic [LINES-1:0] syncLvl;
  logic [LINES-1:0] prevLvl;
  logic [WIDTH-1:0] capReg;

  assign rawLine = {c2In, c1In};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawLine[g]};
      end
      assign syncLvl[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  assign evt.c1Rise = syncLvl[0] & ~prevLvl[0];
  assign evt.c1Fall = ~syncLvl[0] & prevLvl[0];
  assign evt.c2Rise = syncLvl[1] & ~prevLvl[1];
  assign evt.c2Fall = ~syncLvl[1] & prevLvl[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capReg <= '0;
    else if (ctl.capture) capReg <= portIn;
  end

  assign dataOut = latchEn ? capReg : portIn;

endmodule

// File: rtl/phs_control.sv
module phs_control
  import phs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] ctrlField,
  input  logic       latchEn,
  input  logic       portAccess,
  input  logic       handshakeAddr,
  input  edgeEvt_t   evt,
  output ctlStrobe_t ctl,
  output logic       c1Flag,
  output logic       c2Flag,
  output logic       c2Out,
  output logic       c2OutEn
);

  c2mode_e mode;
  logic    hsAcc;
  logic    c1Act;
  logic    c2Act;
  logic    outMode;
  logic    indep;
  logic    hsLevel;
  logic    pulseLow;

  assign mode    = c2mode_e'(ctrlField[3:1]);
  assign outMode = ctrlField[3];
  assign indep   = ctrlField[1];
  assign hsAcc   = portAccess & handshakeAddr;
  assign c1Act   = ctrlField[0] ? evt.c1Rise : evt.c1Fall;
  assign c2Act   = ctrlField[2] ? evt.c2Rise : evt.c2Fall;

  assign ctl.capture = c1Act & latchEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      c1Flag <= 1'b0;
    else if (c1Act) c1Flag <= 1'b1;
    else if (hsAcc) c1Flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                c2Flag <= 1'b0;
    else if (outMode)         c2Flag <= 1'b0;
    else if (c2Act)           c2Flag <= 1'b1;
    else if (hsAcc && !indep) c2Flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     hsLevel <= 1'b1;
    else if (mode != C2_HANDSHAKE) hsLevel <= 1'b1;
    else if (hsAcc)                hsLevel <= 1'b0;
    else if (c1Act)                hsLevel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseLow <= 1'b0;
    else       pulseLow <= hsAcc;
  end

  always_comb begin
    unique case (mode)
      C2_HANDSHAKE: c2Out = hsLevel;
      C2_PULSE:     c2Out = ~pulseLow;
      C2_LOW:       c2Out = 1'b0;
      default:      c2Out = 1'b1;
    endcase
  end

  assign c2OutEn = outMode;

endmodule

// File: rtl/port_handshake_ctrl.sv
module port_handshake_ctrl
  import phs_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ctrlField,
  input  logic             latchEn,
  input  logic             portAccess,
  input  logic             handshakeAddr,
  input  logic             c1In,
  input  logic             c2In,
  input  logic [WIDTH-1:0] portIn,
  output logic             c1Flag,
  output logic             c2Flag,
  output logic             c2Out,
  output logic             c2OutEn,
  output logic [WIDTH-1:0] dataOut
);

  edgeEvt_t   evt;
  ctlStrobe_t ctl;

  phs_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .c1In    (c1In),
    .c2In    (c2In),
    .portIn  (portIn),
    .latchEn (latchEn),
    .ctl     (ctl),
    .evt     (evt),
    .dataOut (dataOut)
  );

  phs_control u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .ctrlField     (ctrlField),
    .latchEn       (latchEn),
    .portAccess    (portAccess),
    .handshakeAddr (handshakeAddr),
    .evt           (evt),
    .ctl           (ctl),
    .c1Flag        (c1Flag),
    .c2Flag        (c2Flag),
    .c2Out         (c2Out),
    .c2OutEn       (c2OutEn)
  );

endmodule

// File: rtl/phs_checker.sv
module phs_checker
  import phs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       ctrlField,
  input logic             latchEn,
  input logic             portAccess,
  input logic             handshakeAddr,
  input logic             c1Flag,
  input logic             c2Flag,
  input logic             c2Out,
  input logic [WIDTH-1:0] dataOut,
  input edgeEvt_t         evt
);

  logic hsAcc;
  logic c1Act;
  logic c2Act;
  assign hsAcc = portAccess & handshakeAddr;
  assign c1Act = ctrlField[0] ? evt.c1Rise : evt.c1Fall;
  assign c2Act = ctrlField[2] ? evt.c2Rise : evt.c2Fall;

  p_c1set_r2: assert property (@(posedge clk) disable iff (!rstN)
    c1Act |=> c1Flag);

  p_c1clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hsAcc && !c1Act) |=> !c1Flag);

  p_c2set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlField[3] && c2Act) |=> c2Flag);

  p_indep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlField[3] && ctrlField[1] && c2Flag) |=> c2Flag);

  p_hsrise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlField[3:1] == 3'b100 && c1Act && !hsAcc) |=> (ctrlField[3:1] != 3'b100 || c2Out));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlField[3:1] == 3'b101 && hsAcc) |=> (ctrlField[3:1] != 3'b101 || !c2Out));

  p_outflag_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlField[3] |=> !c2Flag);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (portAccess && !handshakeAddr && !c1Act) |=> $stable(c1Flag));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && !c1Act) |=> (!latchEn || $stable(dataOut)));

endmodule

bind port_handshake_ctrl phs_checker #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .ctrlField     (ctrlField),
  .latchEn       (latchEn),
  .portAccess    (portAccess),
  .handshakeAddr (handshakeAddr),
  .c1Flag        (c1Flag),
  .c2Flag        (c2Flag),
  .c2Out         (c2Out),
  .dataOut       (dataOut),
  .evt           (evt)
);

// File: tb/port_handshake_ctrl_bench.sv
`timescale 1ns/1ps
module port_handshake_ctrl_bench;

  localparam int W = 8;
  localparam int S = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   ctrlField = 4'h0;
  logic         latchEn = 1'b0;
  logic         portAccess = 1'b0;
  logic         handshakeAddr = 1'b0;
  logic         c1In = 1'b0;
  logic         c2In = 1'b0;
  logic [W-1:0] portIn = '0;
  logic         c1Flag, c2Flag, c2Out, c2OutEn;
  logic [W-1:0] dataOut;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  bit  cmpOn = 1'b0;

  always #4 clk = ~clk;

  port_handshake_ctrl #(.WIDTH(W), .SYNC_STAGES(S)) u_port_handshake_ctrl (
    .clk(clk), .rstN(rstN), .ctrlField(ctrlField), .latchEn(latchEn),
    .portAccess(portAccess), .handshakeAddr(handshakeAddr),
    .c1In(c1In), .c2In(c2In), .portIn(portIn),
    .c1Flag(c1Flag), .c2Flag(c2Flag), .c2Out(c2Out), .c2OutEn(c2OutEn),
    .dataOut(dataOut)
  );

  // Behavioural reference model: pin history lines and plain state
  int h1[0:7];
  int h2[0:7];
  int mC1F = 0, mC2F = 0, mCap = 0, mHsL = 1, mPulse = 0;

  initial begin
    for (int i = 0; i < 8; i++) begin h1[i] = 0; h2[i] = 0; end
  end

  always @(posedge clk) begin
    int mode, hs, a1, a2, r2, f2;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin h1[i] = 0; h2[i] = 0; end
      mC1F = 0; mC2F = 0; mCap = 0; mHsL = 1; mPulse = 0;
    end else begin
      for (int i = 7; i > 0; i--) begin h1[i] = h1[i-1]; h2[i] = h2[i-1]; end
      h1[0] = int'(c1In);
      h2[0] = int'(c2In);
      mode = int'(ctrlField[3:1]);
      hs = int'(portAccess && handshakeAddr);
      a1 = ctrlField[0] ? int'(h1[S] == 1 && h1[S+1] == 0) : int'(h1[S] == 0 && h1[S+1] == 1);
      r2 = int'(h2[S] == 1 && h2[S+1] == 0);
      f2 = int'(h2[S] == 0 && h2[S+1] == 1);
      a2 = (mode == 2 || mode == 3) ? r2 : f2;
      if (a1) mC1F = 1; else if (hs) mC1F = 0;
      if (mode >= 4) mC2F = 0;
      else if (a2) mC2F = 1;
      else if (hs && (mode % 2 == 0)) mC2F = 0;
      if (a1 && latchEn) mCap = int'(portIn);
      if (mode != 4) mHsL = 1; else if (hs) mHsL = 0; else if (a1) mHsL = 1;
      mPulse = hs;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    int mode, eOut;
    if (cmpOn && rstN) begin
      mode = int'(ctrlField[3:1]);
      case (mode)
        4: eOut = mHsL;
        5: eOut = mPulse ? 0 : 1;
        6: eOut = 0;
        default: eOut = 1;
      endcase
      chk("R2 c1Flag", int'(c1Flag), mC1F);
      chk("R3/R4 c2Flag", int'(c2Flag), mC2F);
      chk("R5/R6/R7 c2Out", int'(c2Out), eOut);
      chk("R7 c2OutEn", int'(c2OutEn), int'(mode >= 4));
      chk("R9/R10 dataOut", int'(dataOut), latchEn ? mCap : int'(portIn));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hsAccess(input bit hsa);
    portAccess = 1'b1; handshakeAddr = hsa;
    step(1);
    portAccess = 1'b0; handshakeAddr = 1'b0;
  endtask

  initial begin
    latchEn = 1'b1;
    step(3);
    chk("R1 c1Flag reset", int'(c1Flag), 0);
    chk("R1 c2Flag reset", int'(c2Flag), 0);
    chk("R1 c2Out reset", int'(c2Out), 1);
    chk("R1 c2OutEn reset", int'(c2OutEn), 0);
    chk("R1 capture reset", int'(dataOut), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    step(2);

    // R2 and R9: rising C1 edge, mode 000
    ctrlField = 4'b0001; portIn = 8'hA5; c1In = 1'b1;
    step(S);
    chk("R2 flag not yet set", int'(c1Flag), 0);
    step(1);
    chk("R2 flag set on rising C1", int'(c1Flag), 1);
    chk("R9 captured on C1 edge", int'(dataOut), 'hA5);
    portIn = 8'h3C;
    step(1);
    chk("R9 capture held", int'(dataOut), 'hA5);
    hsAccess(1'b1);
    chk("R2 handshake access clears", int'(c1Flag), 0);

    // R3 and R8: falling C2 edge, mode 000
    c2In = 1'b1; step(S + 2);
    c2In = 1'b0; step(S + 1);
    chk("R3 c2Flag on falling edge", int'(c2Flag), 1);
    hsAccess(1'b0); step(1);
    chk("R8 quiet access keeps c2Flag", int'(c2Flag), 1);
    hsAccess(1'b1);
    chk("R3 handshake access clears c2Flag", int'(c2Flag), 0);

    // R4: rising, independent
    ctrlField = 4'b0111;
    c2In = 1'b1; step(S + 1);
    chk("R4 c2Flag on rising edge", int'(c2Flag), 1);
    hsAccess(1'b1);
    chk("R4 access leaves c2Flag", int'(c2Flag), 1);
    c2In = 1'b0; step(S + 2);

    // R5: handshake output
    ctrlField = 4'b1001; step(1);
    chk("R5 idle high", int'(c2Out), 1);
    chk("R7 output enable", int'(c2OutEn), 1);
    chk("R7 flag cleared in output mode", int'(c2Flag), 0);
    hsAccess(1'b1);
    chk("R5 access drives low", int'(c2Out), 0);
    step(3);
    chk("R5 stays low", int'(c2Out), 0);
    c1In = 1'b0; step(S + 2);
    chk("R5 falling C1 ignored", int'(c2Out), 0);
    c1In = 1'b1; step(S);
    chk("R5 before C1 edge", int'(c2Out), 0);
    step(1);
    chk("R5 C1 edge releases high", int'(c2Out), 1);

    // R6: pulse output
    ctrlField = 4'b1011; step(1);
    hsAccess(1'b1);
    chk("R6 pulse low", int'(c2Out), 0);
    step(1);
    chk("R6 pulse ends", int'(c2Out), 1);
    hsAccess(1'b0);
    chk("R8 quiet access no pulse", int'(c2Out), 1);

    // R7: manual levels
    ctrlField = 4'b1101; step(1);
    chk("R7 manual low", int'(c2Out), 0);
    ctrlField = 4'b1111; step(1);
    chk("R7 manual high", int'(c2Out), 1);
    ctrlField = 4'b0000; step(1);
    chk("R7 input mode no enable", int'(c2OutEn), 0);

    // R10: transparent
    latchEn = 1'b0; portIn = 8'h5A; step(1);
    chk("R10 transparent data", int'(dataOut), 'h5A);

    // Random mix, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) ctrlField = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 31) == 0) latchEn = ~latchEn;
      if ($urandom_range(0, 7) == 0) c1In = ~c1In;
      if ($urandom_range(0, 7) == 0) c2In = ~c2In;
      portIn = 8'($urandom_range(0, 255));
      portAccess = ($urandom_range(0, 5) == 0);
      handshakeAddr = ($urandom_range(0, 1) == 1);
      step(1);
    end
    portAccess = 1'b0;
    step(S + 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule